// File: doc/BRIEF.md
# Station-Address PROM Signature Locator

This block probes an auto-incrementing station-address PROM for the fixed eight-byte marker that precedes the station address. It issues one byte read at a time over a simple request/valid handshake. The first read only resets the PROM's internal counter, and its byte is dropped. The second read decides whether the PROM address counter must first be switched on. That is done with a read-modify-write of the adapter control register, which sets bit 3. The block then scans a bounded window of bytes for the marker.

The scan stops on the very read that completes the marker, so the PROM counter is left pointing at the first station-address byte for whatever logic reads it next. The window is 32 + 8 - 1 = 39 search reads, because the PROM counter can begin anywhere in its 32-byte cycle. When the window runs out without a full match, the block reports not-found. Both results are held with done until the next start pulse.

The matcher is a simple tracker. It is not a full prefix matcher. On a mismatching byte, the match position falls back to 1 if that byte is FF and to 0 otherwise.

Top module: `prom_sig_search`

## Requirements
- R1: While rst_ni is low, and in the cycles after it rises, done_o, found_o, not_found_o, rd_req_o and ctl_we_o are all low. A reset taken in the middle of a scan abandons it, and the next start begins with the match position and read count cleared.
- R2: The byte returned by the first read after start is discarded. Its value has no effect on the control write or on the search result.
- R3: If the byte from the second read equals 0x08, exactly one control write is issued, with data ctl_rdata_i OR 0x08 (bit 3 set), before the first search read. For any other value, no control write occurs.
- R4: At most one read is outstanding. After rd_req_o pulses for one cycle, no new request is made until rd_valid_i has delivered that read's byte.
- R5: The marker is FF 00 55 AA FF 00 55 AA, matched in that order. A mismatching byte restarts the match position at 1 if it is FF, and at 0 otherwise.
- R6: The search ends on the read that completes the eighth marker byte, and no further read is issued. The total read count is therefore 2 plus the search reads up to and including that byte.
- R7: At most 39 search reads are made. If the marker is not complete by then, the result is not-found after exactly 39 search reads.
- R8: found_o and not_found_o are never high together. Exactly one of them is high whenever done_o is high, and all three are held until the next start pulse.
- R9: A start pulse that arrives while a probe is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a probe from idle or done |
| rd_req_o | output | 1 | One-cycle request for the next PROM byte |
| rd_data_i | input | 8 | PROM byte, qualified by rd_valid_i |
| rd_valid_i | input | 1 | PROM byte valid for the outstanding request |
| ctl_rdata_i | input | CTL_W | Current value of the adapter control register |
| ctl_we_o | output | 1 | Control register write strobe |
| ctl_wdata_o | output | CTL_W | Control register write data |
| done_o | output | 1 | Probe finished; result valid |
| found_o | output | 1 | Marker located |
| not_found_o | output | 1 | Window exhausted without the marker |

## Verification
The properties assume that rd_valid_i is raised only while a read is outstanding, at least one cycle after the request, and that it is held until it is consumed. They also assume that ctl_rdata_i reflects the register in the cycle of the write. The bench's PROM model answers each request after one to three cycles and returns bytes strictly in sequence. It never asserts valid without a request, and it keeps the control value steady for a whole probe. The random PROM images use bytes drawn mostly from the marker's own alphabet, so partial matches, restarts and late completions all occur often.

// File: rtl/prom_sig_pkg.sv
package prom_sig_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned SIG_LEN    = 8;
  localparam logic [7:0]  ARM_CODE   = 8'h08;
  localparam int unsigned CNT_EN_BIT = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_ARM,
    ST_SET,
    ST_SRCH,
    ST_DONE
  } state_e;

  function automatic logic [7:0] sig_byte(input int unsigned pos);
    case (pos % 4)
      0:       sig_byte = 8'hFF;
      1:       sig_byte = 8'h00;
      2:       sig_byte = 8'h55;
      default: sig_byte = 8'hAA;
    endcase
  endfunction
endpackage

// File: rtl/sig_matcher.sv
module sig_matcher
  import prom_sig_pkg::*;
#(
  parameter int unsigned LEN   = SIG_LEN,
  localparam int unsigned IDX_W = $clog2(LEN + 1)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [IDX_W-1:0]  idx_next_o,
  output logic              complete_o
);
  logic [LEN-1:0] hit;

  for (genvar g = 0; g < LEN; g++) begin : g_cmp
    assign hit[g] = (byte_i == sig_byte(g));
  end

  logic idx_hit;
  always_comb begin
    idx_hit = 1'b0;
    for (int unsigned k = 0; k < LEN; k++)
      if (idx_i == IDX_W'(k)) idx_hit = hit[k];
  end

  // restart-on-first-byte, no prefix table
  always_comb begin
    if (idx_hit)     idx_next_o = idx_i + IDX_W'(1);
    else if (hit[0]) idx_next_o = IDX_W'(1);
    else             idx_next_o = '0;
  end

  assign complete_o = (idx_next_o == IDX_W'(LEN));
endmodule

// File: rtl/win_counter.sv
module win_counter #(
  parameter int unsigned LIMIT = 39,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             limit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !limit_o) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o   = cnt_q;
  assign limit_o = (cnt_q == CNT_W'(LIMIT));
endmodule

// File: rtl/prom_sig_search.sv
module prom_sig_search
  import prom_sig_pkg::*;
#(
  parameter int unsigned PROBE_LEN = 32,
  parameter int unsigned CTL_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              rd_req_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic              rd_valid_i,
  input  logic [CTL_W-1:0]  ctl_rdata_i,
  output logic              ctl_we_o,
  output logic [CTL_W-1:0]  ctl_wdata_o,
  output logic              done_o,
  output logic              found_o,
  output logic              not_found_o
);
  localparam int unsigned WINDOW = PROBE_LEN + SIG_LEN - 1;
  localparam int unsigned IDX_W  = $clog2(SIG_LEN + 1);
  localparam int unsigned CNT_W  = $clog2(WINDOW + 1);

  state_e           state_q, state_d;
  logic             pend_q, pend_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             found_q, found_d;
  logic             miss_q, miss_d;
  logic             cnt_clr, cnt_inc, cnt_limit;
  logic [CNT_W-1:0] win_cnt;
  logic [IDX_W-1:0] idx_next;
  logic             sig_done;
  logic             accept;

  sig_matcher #(.LEN(SIG_LEN)) i_match (
    .idx_i      (idx_q),
    .byte_i     (rd_data_i),
    .idx_next_o (idx_next),
    .complete_o (sig_done)
  );

  win_counter #(.LIMIT(WINDOW)) i_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .cnt_o   (win_cnt),
    .limit_o (cnt_limit)
  );

  assign accept = pend_q && rd_valid_i;

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    idx_d    = idx_q;
    found_d  = found_q;
    miss_d   = miss_q;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    rd_req_o = 1'b0;
    ctl_we_o = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_CLR;
          pend_d  = 1'b0;
          idx_d   = '0;
          found_d = 1'b0;
          miss_d  = 1'b0;
          cnt_clr = 1'b1;
        end
      end
      ST_CLR: begin
        if (!pend_q) begin
          rd_req_o = 1'b1;
          pend_d   = 1'b1;
        end else if (accept) begin
          pend_d  = 1'b0;
          state_d = ST_ARM;
        end
      end
      ST_ARM: begin
        if (!pend_q) begin
          rd_req_o = 1'b1;
          pend_d   = 1'b1;
        end else if (accept) begin
          pend_d  = 1'b0;
          idx_d   = '0;
          cnt_clr = 1'b1;
          state_d = (rd_data_i == ARM_CODE) ? ST_SET : ST_SRCH;
        end
      end
      ST_SET: begin
        ctl_we_o = 1'b1;
        state_d  = ST_SRCH;
      end
      ST_SRCH: begin
        if (!pend_q) begin
          if (cnt_limit) begin
            miss_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            rd_req_o = 1'b1;
            cnt_inc  = 1'b1;
            pend_d   = 1'b1;
          end
        end else if (accept) begin
          pend_d = 1'b0;
          idx_d  = idx_next;
          if (sig_done) begin
            found_d = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      idx_q   <= '0;
      found_q <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      idx_q   <= idx_d;
      found_q <= found_d;
      miss_q  <= miss_d;
    end
  end

  // counter-enable bit set on top of the live register value
  always_comb begin
    ctl_wdata_o             = ctl_rdata_i;
    ctl_wdata_o[CNT_EN_BIT] = 1'b1;
  end

  assign done_o      = (state_q == ST_DONE);
  assign found_o     = found_q;
  assign not_found_o = miss_q;
endmodule

// File: rtl/prom_sig_search_chk.sv
module prom_sig_search_chk #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned WINDOW = 39
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             rd_req_o,
  input logic             rd_valid_i,
  input logic             ctl_we_o,
  input logic             done_o,
  input logic             found_o,
  input logic             not_found_o,
  input logic             pend_q,
  input logic [CNT_W-1:0] win_cnt
);
  assert_req_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  assert_req_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !rd_valid_i) |=> !rd_req_o);

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(found_o && not_found_o));

  assert_done_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (found_o ^ not_found_o));

  assert_idle_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!found_o && !not_found_o));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(found_o) && $stable(not_found_o)));

  assert_quiet_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_req_o && !ctl_we_o));

  assert_found_on_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(found_o) |-> $past(pend_q && rd_valid_i));

  assert_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt <= CNT_W'(WINDOW));

  assert_single_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_o |=> !ctl_we_o);
endmodule

bind prom_sig_search prom_sig_search_chk #(.CNT_W(CNT_W), .WINDOW(WINDOW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .rd_req_o    (rd_req_o),
  .rd_valid_i  (rd_valid_i),
  .ctl_we_o    (ctl_we_o),
  .done_o      (done_o),
  .found_o     (found_o),
  .not_found_o (not_found_o),
  .pend_q      (pend_q),
  .win_cnt     (win_cnt)
);

// File: tb/test_prom_sig_search.sv
module test_prom_sig_search;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 39;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       rd_req_o;
  logic [7:0] rd_data_i = '0;
  logic       rd_valid_i = 1'b0;
  logic [7:0] ctl_rdata_i = '0;
  logic       ctl_we_o;
  logic [7:0] ctl_wdata_o;
  logic       done_o, found_o, not_found_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] prom [64];
  int ptr, nwr, wr_at, overlap;
  logic [7:0] wval;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prom_sig_search i_prom_sig_search (.*);

  function automatic logic [7:0] mk(input int i);
    case (i % 4)
      0: mk = 8'hFF;
      1: mk = 8'h00;
      2: mk = 8'h55;
      default: mk = 8'hAA;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic void ref_search(output bit f, output int n);
    int idx = 0;
    f = 0;
    n = WIN;
    for (int i = 0; i < WIN; i++) begin
      logic [7:0] b = prom[2+i];
      if (b == mk(idx)) idx++;
      else idx = (b == 8'hFF) ? 1 : 0;
      if (idx == 8) begin
        f = 1;
        n = i + 1;
        return;
      end
    end
  endfunction

  task automatic fill_junk();
    for (int i = 0; i < 64; i++) prom[i] = 8'h11;
  endtask

  task automatic place_sig(input int pos);
    for (int i = 0; i < 8; i++) prom[2+pos+i] = mk(i);
  endtask

  // rst_at > 0: reset is applied once that many reads are served
  task automatic run_case(input string tag, input bit poke, input int rst_at);
    bit ef, poked;
    int en, cyc;
    ref_search(ef, en);
    ptr = 0; nwr = 0; wr_at = -1; overlap = 0; wval = '0; poked = 0; cyc = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    while (!done_o && cyc < 2000) begin
      rd_valid_i = 1'b0;
      start_i = 1'b0;
      if (rst_at > 0 && ptr == rst_at) begin
        rst_ni = 1'b0;
        @(negedge clk_i);
        chk({tag, " R1 done"}, done_o, 0);
        chk({tag, " R1 req"}, rd_req_o, 0);
        @(negedge clk_i) rst_ni = 1'b1;
        @(negedge clk_i);
        chk({tag, " R1 flags"}, {found_o, not_found_o, ctl_we_o}, 0);
        return;
      end
      if (poke && !poked && ptr == 5) begin
        start_i = 1'b1;
        poked = 1;
      end
      if (ctl_we_o) begin
        nwr++;
        wval = ctl_wdata_o;
        wr_at = ptr;
      end
      if (rd_req_o) begin
        int d = $urandom_range(1, 3);
        for (int k = 0; k < d; k++) begin
          @(negedge clk_i);
          start_i = 1'b0;
          cyc++;
          if (rd_req_o) overlap++;
        end
        rd_data_i = prom[ptr];
        ptr++;
        rd_valid_i = 1'b1;
      end
      @(negedge clk_i);
      cyc++;
    end
    rd_valid_i = 1'b0;
    chk({tag, " done"}, done_o, 1);
    chk({tag, " R4 overlap"}, overlap, 0);
    chk({tag, " R5 found"}, found_o, ef);
    chk({tag, " R7 not_found"}, not_found_o, !ef);
    chk({tag, " R6 reads"}, ptr, 2 + en);
    if (prom[1] == 8'h08) begin
      chk({tag, " R3 writes"}, nwr, 1);
      chk({tag, " R3 wdata"}, wval, ctl_rdata_i | 8'h08);
      chk({tag, " R3 order"}, wr_at, 2);
    end else begin
      chk({tag, " R3 nowrite"}, nwr, 0);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      if (rd_req_o || !done_o || found_o !== ef || not_found_o !== !ef) begin
        chk({tag, " R8 hold"}, 0, 1);
        break;
      end
    end
    total++;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk_i);
    chk("R1 reset req", rd_req_o, 0);
    chk("R1 reset done", {done_o, found_o, not_found_o, ctl_we_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", {done_o, rd_req_o, found_o, not_found_o}, 0);

    // R3 R6: arm code, marker at search offset 0
    fill_junk(); prom[1] = 8'h08; ctl_rdata_i = 8'hA1; place_sig(0);
    run_case("early", 0, 0);

    // R7: marker completes on read 39
    fill_junk(); prom[1] = 8'h12; ctl_rdata_i = 8'h00; place_sig(31);
    run_case("last", 0, 0);

    // R7: marker would complete on read 40
    fill_junk(); prom[1] = 8'h08; ctl_rdata_i = 8'h08; place_sig(32);
    run_case("miss", 0, 0);

    // R5: repeated FF restarts at 1
    fill_junk(); prom[1] = 8'h00; prom[2] = 8'hFF; place_sig(1);
    run_case("ffff", 0, 0);

    // R5: FF mismatch at final position
    fill_junk(); prom[1] = 8'h00;
    for (int i = 0; i < 7; i++) prom[2+i] = mk(i);
    place_sig(7);
    run_case("late_ff", 0, 0);

    // R5: non-FF mismatch drops to 0
    fill_junk(); prom[1] = 8'h00;
    for (int i = 0; i < 6; i++) prom[2+i] = mk(i);
    prom[8] = 8'h00;
    place_sig(9);
    run_case("drop", 0, 0);

    // R2: first byte 0x08 ignored, marker split across discarded bytes
    fill_junk(); prom[0] = 8'h08; prom[1] = 8'h00;
    for (int i = 2; i < 8; i++) prom[i] = mk(i);
    run_case("discard", 0, 0);

    // R9: start mid-probe ignored
    fill_junk(); prom[1] = 8'h08; ctl_rdata_i = 8'h40; place_sig(10);
    run_case("restart_ign", 1, 0);

    // R1: reset mid-search, then clean probe
    fill_junk(); prom[1] = 8'h00;
    for (int i = 0; i < 5; i++) prom[2+i] = mk(i);
    run_case("midrst", 0, 6);
    fill_junk(); prom[1] = 8'h00;
    prom[2] = 8'h55; prom[3] = 8'hAA; prom[4] = 8'hFF; prom[5] = 8'h00;
    prom[6] = 8'h55; prom[7] = 8'hAA;
    place_sig(20);
    run_case("post_rst", 0, 0);

    for (int t = 0; t < 24; t++) begin
      logic [7:0] alpha [6] = '{8'hFF, 8'h00, 8'h55, 8'hAA, 8'h08, 8'h3C};
      for (int i = 0; i < 64; i++) prom[i] = alpha[$urandom_range(0, 5)];
      if ($urandom_range(0, 1) == 1) prom[1] = 8'h08;
      if ($urandom_range(0, 2) != 0) place_sig($urandom_range(0, 34));
      ctl_rdata_i = 8'($urandom());
      run_case("rand", 0, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule